// File: doc/BRIEF.md
# PHY Register Handshake Access Engine

This engine sits between a simple request port and a PHY whose 16-bit configuration registers are not memory mapped. The PHY can only be reached through one control word and one status word. A caller presents an address, a read or write flag and, for writes, a data value. The engine then steps through the strobe and acknowledge exchange the PHY expects. It ends with a one-cycle done pulse, an error flag and, for reads, the returned data.

Every phase follows the same four-phase pattern. A strobe is raised and the engine waits for the acknowledge to go high. The strobe is then cleared and the engine waits for the acknowledge to go low. The engine checks the acknowledge at a fixed interval and gives up after a bounded number of checks. If any wait gives up, the operation aborts with an error and the control word is returned to zero.

Top module: `phy_hs_engine`

## Requirements
- R1: The control word `phy_ctrl_o` carries address or data in bits 15:0, capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19. At most one of bits 19:16 is high at any time.
- R2: Every operation starts with an address phase. The address is driven on bits 15:0 alone for one cycle. Capture-address is then added and held until acknowledge is high. The strobe is then dropped with the address kept, and the engine waits for acknowledge low.
- R3: A write continues in three steps. First the data is driven alone for one cycle. Next, data plus capture-data is held until acknowledge goes high, and data alone until it goes low. Then the write strobe is driven alone (bits 18:0 otherwise zero) until acknowledge goes high, and data alone until it goes low. The control word then returns to zero.
- R4: A read continues with the read strobe driven alone until acknowledge goes high. At that point status bits 15:0 are captured. The control word is then zero while the engine waits for acknowledge low. The captured value is held on `rdata_o` after done.
- R5: Acknowledge is status bit 16. Each wait checks it first one cycle after the wait begins, then every POLL_GAP cycles, for at most POLL_LIMIT checks. With the defaults (10 checks, 4 cycles apart), an acknowledge that arrives in time for the last check lets the operation succeed.
- R6: When a wait runs out, the operation aborts. `done_o` pulses with `error_o`=1 and the control word is zero. If acknowledge never rises, done comes 2+(POLL_LIMIT-1)*POLL_GAP cycles after the accepting edge (38 with the defaults). If acknowledge never falls, it comes one cycle later (39).
- R7: `req_i` is accepted only while `busy_o` is low. `busy_o` is high from the accepting edge until the finishing edge. `done_o` is a one-cycle pulse with `busy_o` low. A request raised while busy is ignored: it causes no extra PHY access and no extra done.
- R8: After reset, `busy_o`, `done_o`, `error_o`, `rdata_o` and `phy_ctrl_o` are all zero.
- R9: A completed operation reports `error_o`=0, and a read returns the value most recently written to the same PHY register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, sampled while idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | PHY register address |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Last operation timed out |
| rdata_o | output | 16 | Data from the last read |
| phy_ctrl_o | output | 20 | Control word to the PHY |
| phy_stat_i | input | 17 | Status word: bit 16 acknowledge, 15:0 read data |

## Verification
The assertions assume three things about the environment. Requests are raised only from the idle state or are otherwise harmless. The PHY acknowledge is synchronous to the engine clock. The status word changes only between clock edges. The PHY model in the bench updates its acknowledge and read data on the falling edge. It responds only to the strobes the engine drives. Its delay, withhold and stuck-high settings are changed only while the engine is idle and the acknowledge has settled. The one request raised during an operation deliberately probes the rule that such requests are ignored.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_PRE,
    ST_A_SET,
    ST_A_CLR,
    ST_D_PRE,
    ST_D_SET,
    ST_D_CLR,
    ST_W_SET,
    ST_W_CLR,
    ST_R_SET,
    ST_R_CLR
  } step_e;

  // steps that poll the acknowledge
  function automatic logic step_waits(step_e s);
    return !(s inside {ST_IDLE, ST_A_PRE, ST_D_PRE});
  endfunction

  // level of acknowledge the step is waiting for
  function automatic logic step_wants_high(step_e s);
    return s inside {ST_A_SET, ST_D_SET, ST_W_SET, ST_R_SET};
  endfunction

endpackage

// File: rtl/phy_hs_poller.sv
module phy_hs_poller #(
  parameter int unsigned POLL_LIMIT = 10,
  parameter int unsigned POLL_GAP   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic expect_i,
  input  logic ack_i,
  output logic hit_o,
  output logic timeout_o
);
  localparam int unsigned TRY_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  logic [TRY_W-1:0] try_q;
  logic             gap_zero;
  logic             sample;
  logic             clear;

  assign sample    = active_i && gap_zero;
  assign hit_o     = sample && (ack_i == expect_i);
  assign timeout_o = sample && (ack_i != expect_i) && (try_q == TRY_W'(POLL_LIMIT - 1));
  assign clear     = !active_i || hit_o || timeout_o;

  generate
    if (POLL_GAP > 1) begin : g_gap
      localparam int unsigned GAP_W = $clog2(POLL_GAP);
      logic [GAP_W-1:0] gap_q;
      assign gap_zero = (gap_q == '0);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        gap_q <= '0;
        else if (clear)     gap_q <= '0;
        else if (gap_zero)  gap_q <= GAP_W'(POLL_GAP - 1);
        else                gap_q <= gap_q - 1'b1;
      end
    end else begin : g_nogap
      assign gap_zero = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       try_q <= '0;
    else if (clear)    try_q <= '0;
    else if (gap_zero) try_q <= try_q + 1'b1;
  end

endmodule

// File: rtl/phy_hs_seq.sv
module phy_hs_seq
  import phy_hs_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              hit_i,
  input  logic              timeout_i,
  input  logic [DATA_W-1:0] stat_data_i,
  output step_e             step_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [DATA_W-1:0] rdata_o
);
  step_e             step_q, step_d;
  logic              write_q;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic              done_q, err_q;
  logic              accept, finish_ok;

  assign accept = (step_q == ST_IDLE) && req_i;

  always_comb begin
    step_d    = step_q;
    finish_ok = 1'b0;
    unique case (step_q)
      ST_IDLE:  if (req_i) step_d = ST_A_PRE;
      ST_A_PRE: step_d = ST_A_SET;
      ST_A_SET: if (hit_i) step_d = ST_A_CLR;
      ST_A_CLR: if (hit_i) step_d = write_q ? ST_D_PRE : ST_R_SET;
      ST_D_PRE: step_d = ST_D_SET;
      ST_D_SET: if (hit_i) step_d = ST_D_CLR;
      ST_D_CLR: if (hit_i) step_d = ST_W_SET;
      ST_W_SET: if (hit_i) step_d = ST_W_CLR;
      ST_W_CLR: if (hit_i) begin step_d = ST_IDLE; finish_ok = 1'b1; end
      ST_R_SET: if (hit_i) step_d = ST_R_CLR;
      ST_R_CLR: if (hit_i) begin step_d = ST_IDLE; finish_ok = 1'b1; end
      default:  step_d = ST_IDLE;
    endcase
    if (timeout_i) step_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= finish_ok || timeout_i;
      if (accept) begin
        write_q <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        err_q   <= 1'b0;
      end
      if (timeout_i) err_q <= 1'b1;
      if (step_q == ST_R_SET && hit_i) rdata_q <= stat_data_i;
    end
  end

  assign step_o  = step_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign busy_o  = (step_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/phy_hs_ctrl_mux.sv
module phy_hs_ctrl_mux
  import phy_hs_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  step_e             step_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W+3:0] ctrl_o
);
  localparam int unsigned CAP_A = DATA_W;
  localparam int unsigned CAP_D = DATA_W + 1;
  localparam int unsigned WR    = DATA_W + 2;
  localparam int unsigned RD    = DATA_W + 3;

  always_comb begin
    ctrl_o = '0;
    unique case (step_i)
      ST_A_PRE, ST_A_CLR:           ctrl_o[DATA_W-1:0] = addr_i;
      ST_A_SET: begin
        ctrl_o[DATA_W-1:0] = addr_i;
        ctrl_o[CAP_A]      = 1'b1;
      end
      ST_D_PRE, ST_D_CLR, ST_W_CLR: ctrl_o[DATA_W-1:0] = wdata_i;
      ST_D_SET: begin
        ctrl_o[DATA_W-1:0] = wdata_i;
        ctrl_o[CAP_D]      = 1'b1;
      end
      ST_W_SET:                     ctrl_o[WR] = 1'b1;
      ST_R_SET:                     ctrl_o[RD] = 1'b1;
      default:                      ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/phy_hs_engine.sv
module phy_hs_engine
  import phy_hs_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned POLL_LIMIT = 10,
  parameter int unsigned POLL_GAP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W+3:0] phy_ctrl_o,
  input  logic [DATA_W:0]   phy_stat_i
);
  localparam int unsigned ACK_BIT = DATA_W;

  step_e             step;
  logic [DATA_W-1:0] addr, wdata;
  logic              hit, timeout;

  phy_hs_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .hit_i       (hit),
    .timeout_i   (timeout),
    .stat_data_i (phy_stat_i[DATA_W-1:0]),
    .step_o      (step),
    .addr_o      (addr),
    .wdata_o     (wdata),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .error_o     (error_o),
    .rdata_o     (rdata_o)
  );

  phy_hs_poller #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_poll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (step_waits(step)),
    .expect_i  (step_wants_high(step)),
    .ack_i     (phy_stat_i[ACK_BIT]),
    .hit_o     (hit),
    .timeout_o (timeout)
  );

  phy_hs_ctrl_mux #(.DATA_W(DATA_W)) u_mux (
    .step_i  (step),
    .addr_i  (addr),
    .wdata_i (wdata),
    .ctrl_o  (phy_ctrl_o)
  );

endmodule

// File: rtl/phy_hs_engine_chk.sv
module phy_hs_engine_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic [DATA_W+3:0] phy_ctrl_o
);
  assert_strobe_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phy_ctrl_o[DATA_W+3:DATA_W]));

  assert_wr_alone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_ctrl_o[DATA_W+2] |-> (phy_ctrl_o[DATA_W+1:0] == '0));

  assert_rd_alone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_ctrl_o[DATA_W+3] |-> (phy_ctrl_o[DATA_W+2:0] == '0));

  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (phy_ctrl_o == '0));

  assert_error_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_from_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

endmodule

bind phy_hs_engine phy_hs_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .error_o    (error_o),
  .phy_ctrl_o (phy_ctrl_o)
);

// File: tb/tb_phy_hs_engine.sv
`timescale 1ns/1ps
module tb_phy_hs_engine;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_w = 1'b0;
  logic [DW-1:0] req_a = '0, req_d = '0;
  logic          busy, done, err;
  logic [DW-1:0] rdata;
  logic [DW+3:0] ctrl;
  logic [DW:0]   stat;

  always #2 clk = ~clk;

  phy_hs_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_write_i(req_w),
    .req_addr_i(req_a), .req_wdata_i(req_d), .busy_o(busy), .done_o(done),
    .error_o(err), .rdata_o(rdata), .phy_ctrl_o(ctrl), .phy_stat_i(stat)
  );

  // PHY model, updated on the falling edge
  int            m_delay = 1;
  logic          m_withhold = 1'b0, m_stuck = 1'b0;
  logic          m_ack = 1'b0;
  int            m_cnt = 0;
  logic [DW+3:0] m_prev = '0;
  logic [DW-1:0] m_addr = '0, m_data = '0;
  logic [DW-1:0] m_mem [16];
  int            m_viol = 0, m_wr = 0, m_rd = 0;
  logic          strobe;

  assign strobe = |ctrl[DW+3:DW];
  assign stat = {m_stuck ? 1'b1 : (m_withhold ? 1'b0 : m_ack), m_mem[m_addr[3:0]]};

  initial for (int i = 0; i < 16; i++) m_mem[i] = '0;

  always @(negedge clk) begin
    if (strobe != m_ack) begin
      if (m_cnt >= m_delay - 1) begin m_ack <= strobe; m_cnt <= 0; end
      else m_cnt <= m_cnt + 1;
    end else m_cnt <= 0;
    if (ctrl[DW] && !m_prev[DW]) begin
      if (ctrl[DW-1:0] != m_prev[DW-1:0]) m_viol <= m_viol + 1;
      m_addr <= ctrl[DW-1:0];
    end
    if (ctrl[DW+1] && !m_prev[DW+1]) begin
      if (ctrl[DW-1:0] != m_prev[DW-1:0]) m_viol <= m_viol + 1;
      m_data <= ctrl[DW-1:0];
    end
    if (ctrl[DW+2] && !m_prev[DW+2]) begin
      if (ctrl[DW+1:0] != '0) m_viol <= m_viol + 1;
      m_mem[m_addr[3:0]] <= m_data;
      m_wr <= m_wr + 1;
    end
    if (ctrl[DW+3] && !m_prev[DW+3]) begin
      if (ctrl[DW+2:0] != '0) m_viol <= m_viol + 1;
      m_rd <= m_rd + 1;
    end
    m_prev <= ctrl;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  // one operation; lat = cycles from accepting edge to done
  task automatic run_op(input logic w, input logic [DW-1:0] a, input logic [DW-1:0] d,
                        input int inject_at, output logic e, output logic [DW-1:0] rd,
                        output int lat);
    @(negedge clk);
    req = 1'b1; req_w = w; req_a = a; req_d = d;
    @(negedge clk);
    req = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    lat = 0;
    while (!done && lat < 3000) begin
      if (lat == inject_at && inject_at > 0) begin
        req = 1'b1; req_w = 1'b1; req_a = 16'h0006; req_d = 16'h5555;
      end else req = 1'b0;
      @(negedge clk);
      lat++;
    end
    req = 1'b0;
    e = err; rd = rdata;
    check(done && !busy, "R7 done pulse with busy low", {done, busy}, 2);
    check(ctrl == '0, "R1 control word zero at done", ctrl, 0);
    @(negedge clk);
    check(!done, "R7 done is one cycle", done, 0);
    repeat (m_delay + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && rdata == '0 && ctrl == '0, "R8 reset state",
          {busy, done, err, rdata, ctrl}, 0);
  endtask

  task automatic t_write_read(input int dly, input logic [DW-1:0] a, input logic [DW-1:0] d);
    logic e; logic [DW-1:0] rd; int lat; int wr0, rd0;
    m_delay = dly; wr0 = m_wr; rd0 = m_rd;
    run_op(1'b1, a, d, 0, e, rd, lat);
    check(!e, "R9 write ok", e, 0);
    check(m_wr == wr0 + 1 && m_addr == a, "R3 one write strobe at address", m_addr, a);
    check(m_mem[a[3:0]] == d, "R3 written data", m_mem[a[3:0]], d);
    run_op(1'b0, a, 16'hffff, 0, e, rd, lat);
    check(!e, "R9 read ok", e, 0);
    check(m_rd == rd0 + 1, "R4 one read strobe", m_rd - rd0, 1);
    check(rd == d, "R4 R9 read data", rd, d);
    check(m_viol == 0, "R2 address and data presented before capture", m_viol, 0);
  endtask

  task automatic t_withhold();
    logic e; logic [DW-1:0] rd; int lat;
    m_delay = 1; m_withhold = 1'b1;
    run_op(1'b1, 16'h0003, 16'h7777, 0, e, rd, lat);
    m_withhold = 1'b0;
    check(e, "R6 error when ack never rises", e, 1);
    check(lat == 38, "R6 R5 timeout latency ack high", lat, 38);
    check(m_mem[3] != 16'h7777, "R6 no write after abort", m_mem[3], 0);
  endtask

  task automatic t_stuck();
    logic e; logic [DW-1:0] rd; int lat;
    m_stuck = 1'b1;
    run_op(1'b0, 16'h0002, 16'h0000, 0, e, rd, lat);
    m_stuck = 1'b0;
    check(e, "R6 error when ack never falls", e, 1);
    check(lat == 39, "R6 R5 timeout latency ack low", lat, 39);
  endtask

  task automatic t_boundary();
    logic e; logic [DW-1:0] rd; int lat;
    t_write_read(37, 16'h0009, 16'h9c3e);
    m_delay = 38;
    run_op(1'b1, 16'h000a, 16'h1111, 0, e, rd, lat);
    check(e, "R5 ack one cycle too late times out", e, 1);
    check(m_mem[10] == '0, "R5 late ack write not done", m_mem[10], 0);
    m_delay = 1;
  endtask

  task automatic t_ignore();
    logic e; logic [DW-1:0] rd; int lat; int wr0;
    m_delay = 2;
    run_op(1'b1, 16'h0006, 16'h0606, 0, e, rd, lat);
    wr0 = m_wr;
    run_op(1'b1, 16'h0005, 16'haaaa, 4, e, rd, lat);
    check(m_wr == wr0 + 1, "R7 request while busy ignored", m_wr - wr0, 1);
    check(!busy, "R7 no second operation", busy, 0);
    run_op(1'b0, 16'h0006, 16'h0000, 0, e, rd, lat);
    check(rd == 16'h0606, "R7 ignored request left register", rd, 16'h0606);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read(1, 16'h0001, 16'hbeef);
    t_write_read(3, 16'h1005, 16'h0028);
    t_write_read(20, 16'h00fe, 16'h8001);
    t_write_read(1, 16'h0001, 16'h0000);
    t_withhold();
    t_stuck();
    t_write_read(2, 16'h0004, 16'h4321);
    t_boundary();
    t_ignore();
    finish_run();
  end

endmodule